// File: doc/BRIEF.md
# Cellular Automaton Test Pattern Generator

This block produces a stream of test bytes for filling a 16-byte instruction buffer during built-in self-test. The patterns come from an 11-cell, one-dimensional, null-boundary cellular automaton. Each cell's next value depends only on the cell itself and its immediate neighbours. The automaton has two next-state functions. The normal function is linear, and by default each cell takes itself XOR its lower neighbour. The dual function is the bitwise complement of the normal one. Both functions close on themselves after 16 steps, so one cycle of either function supplies exactly one buffer filling. Each emitted state contributes its upper 8 bits as one test byte.

A traversal sequencer moves between the two functions by flipping the most significant state bit. One traversal runs as follows. The current seed is recorded as the anchor. The MSB of S0 is inverted to form S1, and a full dual cycle starting at S1 is emitted. S0 then becomes the normal successor of S1, and a full normal cycle starting at S0 is emitted. The rounds repeat until S0 comes back to the anchor. A round guard ends a traversal that runs too long and flags it.

Bytes leave on a valid/ready stream. A byte counts as consumed only in a cycle where valid and ready are both high. While ready is low, the byte and its boundary flag are held unchanged, and the automaton does not advance. The control pins `start` and `seed_load` and the status pins `done` and `error` are plain levels, sampled on the rising clock edge.

Top module: `ca_tpg`

## Requirements
- R1: A synchronous active-high reset clears valid, done and error, and loads SEED_INIT (default 11'h2A5) into the S0 register.
- R2: The test byte is bits [10:3] of the 11-bit state. In the normal function, state bit i for i>0 becomes s[i] XOR s[i-1], and bit 0 keeps its value.
- R3: In the dual function, the next state is the bitwise complement of the normal next state. A dual cycle emits 16 bytes.
- R4: A `start` seen while idle makes the first byte that of S1 = S0 XOR 11'h400 in the next cycle. After the 16 dual bytes, S0 becomes the normal successor of S1 and 16 normal bytes follow. The next round begins with S1 = S0 XOR 11'h400.
- R5: The traversal ends after the normal cycle in which S0 equals the anchor. For a seed whose bits [2:0] are not all zero, this takes exactly 512 bytes. In the cycle after the final handshake, `done` is high and valid is low.
- R6: The stream advances only on valid and ready both high. While valid is high and ready is low, the byte and `tp_last` hold steady.
- R7: `tp_last` is high on the 16th byte of every cycle, and only there.
- R8: While a traversal runs, `start` and `seed_load` have no effect.
- R9: If MAX_ROUNDS rounds complete without a return to the anchor, the traversal stops with both `done` and `error` high.
- R10: When idle, `seed_load` replaces S0 with `seed_in`. If `start` arrives in the same cycle as `seed_load`, it is ignored. A fresh `start` clears `done` and `error`. After a traversal, S0 equals the anchor, so a new start without a load repeats the same sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a traversal (idle only) |
| seed_load | input | 1 | Load `seed_in` into S0 (idle only) |
| seed_in | input | 11 | Seed value |
| tp_ready | input | 1 | Consumer accepts the byte |
| tp_valid | output | 1 | A test byte is offered |
| tp_data | output | 8 | Test byte, state bits [10:3] |
| tp_last | output | 1 | Last byte of a 16-byte filling |
| done | output | 1 | Traversal finished (level) |
| error | output | 1 | Traversal stopped by the round guard |

## Verification
After a `start` sampled on one rising edge, the first byte is valid from that same edge. The bench therefore looks at the stream at the following falling edge, and at every later falling edge where valid and ready are both high it compares against the next queued expected byte. `done` must be high at the falling edge right after the last handshake, so the monitor checks it one sample after the queue empties. Stall checks compare the byte held across two consecutive falling-edge samples. Inputs change one time unit after a rising edge, so each sample sees settled values.

// File: rtl/ca_tpg_pkg.sv
package ca_tpg_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_DUAL = 2'd1,
    PH_NORM = 2'd2
  } phase_e;
endpackage

// File: rtl/ca_tpg_rule.sv
module ca_tpg_rule #(
  parameter int          W         = 11,
  parameter logic [W-1:0] USE_LEFT  = '1,
  parameter logic [W-1:0] USE_SELF  = '1,
  parameter logic [W-1:0] USE_RIGHT = '0,
  parameter bit          INVERT    = 1'b0
) (
  input  logic [W-1:0] cur,
  output logic [W-1:0] nxt
);
  for (genvar i = 0; i < W; i++) begin : g_cell
    logic lo_nb;
    logic hi_nb;
    if (i == 0) begin : g_lo_edge
      assign lo_nb = 1'b0;
    end else begin : g_lo_in
      assign lo_nb = cur[i-1];
    end
    if (i == W-1) begin : g_hi_edge
      assign hi_nb = 1'b0;
    end else begin : g_hi_in
      assign hi_nb = cur[i+1];
    end
    assign nxt[i] = INVERT ^ ((USE_LEFT[i] & lo_nb) ^
                              (USE_SELF[i] & cur[i]) ^
                              (USE_RIGHT[i] & hi_nb));
  end
endmodule

// File: rtl/ca_tpg_seq.sv
module ca_tpg_seq
  import ca_tpg_pkg::*;
#(
  parameter int           W          = 11,
  parameter int           CYCLE_LEN  = 16,
  parameter int           MAX_ROUNDS = 64,
  parameter logic [W-1:0] SEED_INIT  = 11'h2A5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         seed_load,
  input  logic [W-1:0] seed_in,
  input  logic         out_ready,
  input  logic [W-1:0] norm_nxt,
  input  logic [W-1:0] dual_nxt,
  input  logic [W-1:0] s1_norm,
  output logic [W-1:0] state_q,
  output logic [W-1:0] s1_q,
  output logic         running,
  output logic         step_last,
  output logic         done_q,
  output logic         err_q
);
  localparam int           STEP_W   = $clog2(CYCLE_LEN);
  localparam int           RND_W    = $clog2(MAX_ROUNDS + 1);
  localparam logic [W-1:0] MSB_MASK = {1'b1, {(W-1){1'b0}}};

  phase_e            phase;
  logic [STEP_W-1:0] step;
  logic [RND_W-1:0]  rounds;
  logic [RND_W-1:0]  rounds_inc;
  logic [W-1:0]      s0_q;
  logic [W-1:0]      anchor_q;
  logic              fire;

  assign running    = (phase != PH_IDLE);
  assign step_last  = (step == STEP_W'(CYCLE_LEN - 1));
  assign fire       = running && out_ready;
  assign rounds_inc = rounds + RND_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      step     <= '0;
      rounds   <= '0;
      state_q  <= '0;
      s0_q     <= SEED_INIT;
      s1_q     <= '0;
      anchor_q <= '0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else if (phase == PH_IDLE) begin
      if (seed_load) begin
        s0_q <= seed_in;
      end else if (start) begin
        anchor_q <= s0_q;
        s1_q     <= s0_q ^ MSB_MASK;
        state_q  <= s0_q ^ MSB_MASK;
        step     <= '0;
        rounds   <= '0;
        done_q   <= 1'b0;
        err_q    <= 1'b0;
        phase    <= PH_DUAL;
      end
    end else if (fire) begin
      if (!step_last) begin
        step    <= step + STEP_W'(1);
        state_q <= (phase == PH_DUAL) ? dual_nxt : norm_nxt;
      end else begin
        step <= '0;
        if (phase == PH_DUAL) begin
          s0_q    <= s1_norm;
          state_q <= s1_norm;
          phase   <= PH_NORM;
        end else if (s0_q == anchor_q) begin
          phase  <= PH_IDLE;
          done_q <= 1'b1;
        end else if (rounds_inc == RND_W'(MAX_ROUNDS)) begin
          phase  <= PH_IDLE;
          done_q <= 1'b1;
          err_q  <= 1'b1;
        end else begin
          rounds  <= rounds_inc;
          s1_q    <= s0_q ^ MSB_MASK;
          state_q <= s0_q ^ MSB_MASK;
          phase   <= PH_DUAL;
        end
      end
    end
  end
endmodule

// File: rtl/ca_tpg.sv
module ca_tpg #(
  parameter int                 STATE_W    = 11,
  parameter int                 BYTE_W     = 8,
  parameter int                 CYCLE_LEN  = 16,
  parameter int                 MAX_ROUNDS = 64,
  parameter logic [STATE_W-1:0] SEED_INIT  = 11'h2A5,
  parameter logic [STATE_W-1:0] USE_LEFT   = '1,
  parameter logic [STATE_W-1:0] USE_SELF   = '1,
  parameter logic [STATE_W-1:0] USE_RIGHT  = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               seed_load,
  input  logic [STATE_W-1:0] seed_in,
  input  logic               tp_ready,
  output logic               tp_valid,
  output logic [BYTE_W-1:0]  tp_data,
  output logic               tp_last,
  output logic               done,
  output logic               error
);
  logic [STATE_W-1:0] state_q;
  logic [STATE_W-1:0] s1_q;
  logic [STATE_W-1:0] norm_nxt;
  logic [STATE_W-1:0] dual_nxt;
  logic [STATE_W-1:0] s1_norm;
  logic               running;
  logic               step_last;

  ca_tpg_rule #(.W(STATE_W), .USE_LEFT(USE_LEFT), .USE_SELF(USE_SELF),
                .USE_RIGHT(USE_RIGHT), .INVERT(1'b0))
    u_rule_norm (.cur(state_q), .nxt(norm_nxt));

  ca_tpg_rule #(.W(STATE_W), .USE_LEFT(USE_LEFT), .USE_SELF(USE_SELF),
                .USE_RIGHT(USE_RIGHT), .INVERT(1'b1))
    u_rule_dual (.cur(state_q), .nxt(dual_nxt));

  ca_tpg_rule #(.W(STATE_W), .USE_LEFT(USE_LEFT), .USE_SELF(USE_SELF),
                .USE_RIGHT(USE_RIGHT), .INVERT(1'b0))
    u_rule_jump (.cur(s1_q), .nxt(s1_norm));

  ca_tpg_seq #(.W(STATE_W), .CYCLE_LEN(CYCLE_LEN), .MAX_ROUNDS(MAX_ROUNDS),
               .SEED_INIT(SEED_INIT))
    u_seq (
      .clk       (clk),
      .rst       (rst),
      .start     (start),
      .seed_load (seed_load),
      .seed_in   (seed_in),
      .out_ready (tp_ready),
      .norm_nxt  (norm_nxt),
      .dual_nxt  (dual_nxt),
      .s1_norm   (s1_norm),
      .state_q   (state_q),
      .s1_q      (s1_q),
      .running   (running),
      .step_last (step_last),
      .done_q    (done),
      .err_q     (error)
    );

  assign tp_valid = running;
  assign tp_data  = state_q[STATE_W-1 -: BYTE_W];
  assign tp_last  = running && step_last;
endmodule

// File: rtl/ca_tpg_checker.sv
module ca_tpg_checker #(
  parameter int BYTE_W    = 8,
  parameter int CYCLE_LEN = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              seed_load,
  input logic              tp_ready,
  input logic              tp_valid,
  input logic [BYTE_W-1:0] tp_data,
  input logic              tp_last,
  input logic              done,
  input logic              error
);
  localparam int CW = $clog2(CYCLE_LEN);
  logic [CW-1:0] hs_cnt;

  always_ff @(posedge clk) begin
    if (rst) hs_cnt <= '0;
    else if (tp_valid && tp_ready)
      hs_cnt <= (hs_cnt == CW'(CYCLE_LEN - 1)) ? '0 : hs_cnt + CW'(1);
  end

  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> !tp_valid && !done && !error);

  p_start_runs_r4: assert property (@(posedge clk) disable iff (rst)
    !tp_valid && start && !seed_load |=> tp_valid);

  p_done_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    done |-> !tp_valid);

  p_stall_hold_r6: assert property (@(posedge clk) disable iff (rst)
    tp_valid && !tp_ready |=> tp_valid && $stable(tp_data) && $stable(tp_last));

  p_last_pos_r7: assert property (@(posedge clk) disable iff (rst)
    tp_valid |-> (tp_last == (hs_cnt == CW'(CYCLE_LEN - 1))));

  p_err_done_r9: assert property (@(posedge clk) disable iff (rst)
    error |-> done);
endmodule

bind ca_tpg ca_tpg_checker #(.BYTE_W(BYTE_W), .CYCLE_LEN(CYCLE_LEN)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .seed_load (seed_load),
  .tp_ready  (tp_ready),
  .tp_valid  (tp_valid),
  .tp_data   (tp_data),
  .tp_last   (tp_last),
  .done      (done),
  .error     (error)
);

// File: tb/ca_tpg_tb_top.sv
`timescale 1ns/1ps
module ca_tpg_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        seed_load = 1'b0;
  logic [10:0] seed_in = '0;
  logic        tp_ready = 1'b1;
  logic        tp_valid, tp_last, done, error;
  logic [7:0]  tp_data;
  logic        g_valid, g_last, g_done, g_error;
  logic [7:0]  g_data;

  int checks = 0;
  int errors = 0;
  int hs_count = 0;
  int g_count = 0;
  int ready_mode = 0;
  logic [8:0] exp_q[$];

  always #2.5 clk = ~clk;

  ca_tpg dut_i (
    .clk(clk), .rst(rst), .start(start), .seed_load(seed_load),
    .seed_in(seed_in), .tp_ready(tp_ready), .tp_valid(tp_valid),
    .tp_data(tp_data), .tp_last(tp_last), .done(done), .error(error));

  ca_tpg #(.MAX_ROUNDS(4)) dut_g (
    .clk(clk), .rst(rst), .start(start), .seed_load(seed_load),
    .seed_in(seed_in), .tp_ready(1'b1), .tp_valid(g_valid),
    .tp_data(g_data), .tp_last(g_last), .done(g_done), .error(g_error));

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [10:0] t_norm(input logic [10:0] x);
    logic [10:0] y;
    y[0] = x[0];
    for (int i = 1; i < 11; i++) y[i] = x[i] ^ x[i-1];
    return y;
  endfunction

  // Driver: expected stream of one traversal per R2, R3, R4, R5, R7, R9
  task automatic push_traversal(input logic [10:0] seed, input int max_rounds);
    logic [10:0] s0, s1, x;
    int rounds = 0;
    s0 = seed;
    forever begin
      s1 = s0 ^ 11'h400;
      x = s1;
      for (int k = 0; k < 16; k++) begin
        exp_q.push_back({x[10:3], k == 15});
        x = ~t_norm(x);
      end
      s0 = t_norm(s1);
      x = s0;
      for (int k = 0; k < 16; k++) begin
        exp_q.push_back({x[10:3], k == 15});
        x = t_norm(x);
      end
      rounds++;
      if (s0 == seed || rounds == max_rounds) break;
    end
  endtask

  task automatic pulse(input logic do_start, input logic do_load, input logic [10:0] s);
    @(posedge clk); #1;
    start = do_start; seed_load = do_load; seed_in = s;
    @(posedge clk); #1;
    start = 1'b0; seed_load = 1'b0;
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!done);
  endtask

  // Ready pattern generator
  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk); #1;
      cyc++;
      tp_ready = (ready_mode == 0) ? 1'b1 : (((cyc * 7) % 5) != 0 && (cyc % 13) != 4);
    end
  end

  // Monitor / scoreboard
  initial begin
    logic       pend_done = 1'b0;
    logic       prev_stall = 1'b0;
    logic [8:0] prev_item = '0;
    logic [8:0] e;
    forever begin
      @(negedge clk);
      if (g_valid) g_count++;
      if (pend_done) begin
        check(done && !tp_valid && !error, "R5 done after final byte",
              {done, tp_valid, error}, 3'b100);
        pend_done = 1'b0;
      end
      if (prev_stall) begin
        check(tp_valid && {tp_data, tp_last} == prev_item, "R6 hold under stall",
              {tp_data, tp_last}, prev_item);
      end
      prev_stall = tp_valid && !tp_ready;
      prev_item = {tp_data, tp_last};
      if (tp_valid && tp_ready) begin
        hs_count++;
        if (exp_q.size() == 0) begin
          check(1'b0, "R4 unexpected byte", tp_data, 0);
        end else begin
          e = exp_q.pop_front();
          check(tp_data == e[8:1], "R2 R3 R4 byte", tp_data, e[8:1]);
          check(tp_last == e[0], "R7 boundary", tp_last, e[0]);
          if (exp_q.size() == 0) pend_done = 1'b1;
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check(!tp_valid && !done && !error, "R1 reset state", {tp_valid, done, error}, 0);

    // Run A: reset seed, free-flowing consumer, guard instance alongside
    ready_mode = 0;
    hs_count = 0;
    push_traversal(11'h2A5, 64);
    pulse(1'b1, 1'b0, '0);
    wait_done();
    @(negedge clk);
    check(hs_count == 512, "R5 byte count", hs_count, 512);
    check(exp_q.size() == 0, "R1 R5 queue drained", exp_q.size(), 0);
    check(g_done && g_error, "R9 guard stop", {g_done, g_error}, 2'b11);
    check(g_count == 128, "R9 guard byte count", g_count, 128);

    // Run B: loaded seed, stalling consumer, busy start/load ignored
    ready_mode = 1;
    pulse(1'b0, 1'b1, 11'h5C3);
    hs_count = 0;
    push_traversal(11'h5C3, 64);
    pulse(1'b1, 1'b0, '0);
    repeat (100) @(posedge clk);
    pulse(1'b1, 1'b1, 11'h111);   // R8: must be ignored
    check(tp_valid, "R8 still running", tp_valid, 1);
    wait_done();
    @(negedge clk);
    check(hs_count == 512, "R8 byte count", hs_count, 512);

    // Run C: restart without load repeats the same traversal
    push_traversal(11'h5C3, 64);
    pulse(1'b1, 1'b0, '0);
    @(negedge clk);
    check(!done && !error, "R10 start clears status", {done, error}, 0);
    wait_done();
    @(negedge clk);
    check(exp_q.size() == 0, "R8 R10 repeat drained", exp_q.size(), 0);

    // Load and start together: start ignored, then new seed used
    pulse(1'b1, 1'b1, 11'h0F1);
    @(negedge clk);
    check(!tp_valid && done, "R10 start ignored with load", {tp_valid, done}, 2'b01);
    ready_mode = 0;
    push_traversal(11'h0F1, 64);
    pulse(1'b1, 1'b0, '0);
    wait_done();
    @(negedge clk);
    check(exp_q.size() == 0, "R10 new seed drained", exp_q.size(), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule